// File: doc/BRIEF.md
# Backplane Clock and Reset Generator

This block produces the timing and reset for a 32-bit backplane from one reference clock that runs at four times the backplane rate. From a 40 MHz reference it makes the 10 MHz backplane clock, which is active-low: it is high for three reference cycles and low for one. It also makes a 20 MHz double-rate clock for 2X block transfers, phase-locked to the backplane clock, and an active-low enable output that tells the backplane drivers when the double-rate clock can be used.

The PCI reset is the only reset. While PCI reset is asserted, the backplane reset is asserted, both clocks are parked low, the double-rate enable is withdrawn and the interrupt-enable bit is cleared. The release of PCI reset passes through a two-stage synchronizer. After that the clocks start, and the backplane reset is held for a set number of backplane clock cycles. It is then released on a backplane clock rising edge. A backplane interrupt request, which is active low, is forwarded to the single PCI interrupt line when the enable bit is set and the backplane is out of reset. The PCI line is open-drain, so the block gives only a pull-low drive request.

A three-state sequencer controls the reset. ST_HOLD is the state while reset is asserted or its release is not yet synchronized. The transition rel_seen leads from ST_HOLD to ST_STRETCH, which counts backplane clock rising edges. The transition stretch_done, taken on the last counted rising edge, leads to ST_RUN. ST_RUN is left only by a new PCI reset (transition pci_reset, from any state to ST_HOLD).

Top module: `bpclk_gen`

## Requirements
- R1: While pci_rst_n is low, the following hold immediately and for as long as reset stays low: bp_rst_n is 0, pci_int_oe is 0, clk2x_en_n is 1, and both bp_clk_n and clk2x_n are 0.
- R2: Outside reset, bp_clk_n repeats every 4 clk_ref cycles as high, high, high, low. The first sample after a rising edge is cycle 0, and the clock is low only in cycle 3.
- R3: Outside reset, clk2x_n alternates every clk_ref cycle, giving half the backplane period. It is 1 in every cycle in which bp_clk_n has just risen, so one of its rising edges coincides with each backplane rising edge.
- R4: clk2x_en_n is 0 exactly while bp_rst_n is 1, and 1 otherwise.
- R5: The release of pci_rst_n is synchronized through 2 clk_ref edges. The first bp_clk_n rising edge comes on the 3rd clk_ref edge after the release. bp_rst_n stays 0 across BP_RST_CYCLES (default 4) bp_clk_n rising edges and rises to 1 on the edge that follows, in the same cycle as a bp_clk_n rising edge.
- R6: In ST_RUN, pci_int_oe equals irq_en AND (bp_irq_n == 0), with 2 clk_ref cycles of latency from irq_en. While bp_rst_n is 0, pci_int_oe is 0.
- R7: A change on bp_irq_n reaches pci_int_oe after exactly 3 clk_ref edges: two synchronizer stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, 4x the backplane clock |
| pci_rst_n | input | 1 | PCI reset, active low, asynchronous assert |
| irq_en | input | 1 | Interrupt forwarding enable bit |
| bp_irq_n | input | 1 | Backplane interrupt request, active low, asynchronous |
| bp_clk_n | output | 1 | Backplane clock, active low, 75/25 high/low |
| clk2x_n | output | 1 | Double-rate clock for 2X transfers |
| clk2x_en_n | output | 1 | Double-rate clock enable, active low |
| bp_rst_n | output | 1 | Backplane reset, active low |
| pci_int_oe | output | 1 | 1 = pull the open-drain PCI interrupt line low |

## Verification
The properties assume that PCI reset is the only way the block returns to ST_HOLD. They also assume that clk_ref runs without gaps, because the 75/25 shape and the 2X toggle are judged one reference edge at a time. The stimulus changes irq_en and bp_irq_n only on falling reference edges and asserts PCI reset away from any rising edge, so the synchronizers never see a setup-time race and the latencies stay exact. PCI reset is asserted in the middle of ST_RUN, which tests that the clocks, the enable and the interrupt drive are all cleared asynchronously.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
    // Reference cycles per backplane clock period
    localparam int unsigned REF_PER_BP = 4;
    localparam int unsigned PH_W       = $clog2(REF_PER_BP);

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } bpg_state_e;
endpackage

// File: rtl/bpg_sync.sv
module bpg_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bpg_phase.sv
module bpg_phase
    import bpg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rel,
    output logic tick,
    output logic bp_clk_n,
    output logic clk2x_n
);
    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] ph_nxt;
    logic            bp_q;
    logic            x2_q;

    // Phase 0 is the single low quarter; phase 1 follows the rising edge
    always_comb begin
        if (rel) begin
            ph_nxt = ph_q + 1'b1;
        end else begin
            ph_nxt = '0;
        end
        tick = rel && (ph_nxt == PH_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
            bp_q <= 1'b0;
            x2_q <= 1'b0;
        end else begin
            ph_q <= ph_nxt;
            bp_q <= (ph_nxt != '0);
            x2_q <= ph_nxt[0];
        end
    end

    assign bp_clk_n = bp_q;
    assign clk2x_n  = x2_q;
endmodule

// File: rtl/bpg_rst_seq.sv
module bpg_rst_seq
    import bpg_pkg::*;
#(
    parameter int unsigned BP_RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rel,
    input  logic tick,
    output logic bp_rst_n,
    output logic clk2x_en_n
);
    localparam int unsigned CNT_W = (BP_RST_CYCLES > 1) ? $clog2(BP_RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BP_RST_CYCLES - 1);

    bpg_state_e       st_q;
    bpg_state_e       st_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        st_nxt  = st_q;
        cnt_nxt = cnt_q;
        unique case (st_q)
            ST_HOLD: begin
                cnt_nxt = '0;
                if (rel) begin
                    st_nxt = ST_STRETCH;
                end
            end
            ST_STRETCH: begin
                if (tick) begin
                    if (cnt_q == CNT_LAST) begin
                        st_nxt = ST_RUN;
                    end else begin
                        cnt_nxt = cnt_q + 1'b1;
                    end
                end
            end
            ST_RUN: begin
                st_nxt = ST_RUN;
            end
            default: begin
                st_nxt = ST_HOLD;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_HOLD;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    // Registered outputs from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bp_rst_n   <= 1'b0;
            clk2x_en_n <= 1'b1;
        end else begin
            bp_rst_n   <= (st_nxt == ST_RUN);
            clk2x_en_n <= (st_nxt != ST_RUN);
        end
    end
endmodule

// File: rtl/bpclk_gen.sv
module bpclk_gen #(
    parameter int unsigned BP_RST_CYCLES = 4,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk_ref,
    input  logic pci_rst_n,
    input  logic irq_en,
    input  logic bp_irq_n,
    output logic bp_clk_n,
    output logic clk2x_n,
    output logic clk2x_en_n,
    output logic bp_rst_n,
    output logic pci_int_oe
);
    logic rel;
    logic tick;
    logic irq_s_n;
    logic en_q;
    logic oe_q;

    bpg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rel_sync (
        .clk   (clk_ref),
        .rst_n (pci_rst_n),
        .d     (1'b1),
        .q     (rel)
    );

    bpg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_irq_sync (
        .clk   (clk_ref),
        .rst_n (pci_rst_n),
        .d     (bp_irq_n),
        .q     (irq_s_n)
    );

    bpg_phase u_phase (
        .clk      (clk_ref),
        .rst_n    (pci_rst_n),
        .rel      (rel),
        .tick     (tick),
        .bp_clk_n (bp_clk_n),
        .clk2x_n  (clk2x_n)
    );

    bpg_rst_seq #(.BP_RST_CYCLES(BP_RST_CYCLES)) u_seq (
        .clk        (clk_ref),
        .rst_n      (pci_rst_n),
        .rel        (rel),
        .tick       (tick),
        .bp_rst_n   (bp_rst_n),
        .clk2x_en_n (clk2x_en_n)
    );

    // Enable bit cleared by PCI reset; drive request gated by run state
    always_ff @(posedge clk_ref or negedge pci_rst_n) begin
        if (!pci_rst_n) begin
            en_q <= 1'b0;
            oe_q <= 1'b0;
        end else begin
            en_q <= irq_en;
            oe_q <= bp_rst_n && en_q && !irq_s_n;
        end
    end

    assign pci_int_oe = oe_q;
endmodule

// File: rtl/bpg_chk.sv
module bpg_chk (
    input logic clk_ref,
    input logic pci_rst_n,
    input logic bp_clk_n,
    input logic clk2x_n,
    input logic clk2x_en_n,
    input logic bp_rst_n,
    input logic pci_int_oe
);
    // R2: the low quarter lasts exactly one reference cycle
    p_low_one_r2: assert property (@(posedge clk_ref) disable iff (!pci_rst_n)
        (bp_rst_n && !bp_clk_n) |=> bp_clk_n);

    // R2: never more than three high cycles in a row
    p_high_three_r2: assert property (@(posedge clk_ref) disable iff (!pci_rst_n)
        (bp_rst_n && bp_clk_n && $past(bp_clk_n) && $past(bp_clk_n, 2)) |=> !bp_clk_n);

    // R3: each backplane rising edge is also a 2X rising edge
    p_x2_align_r3: assert property (@(posedge clk_ref) disable iff (!pci_rst_n)
        $rose(bp_clk_n) |-> $rose(clk2x_n));

    // R3: the 2X clock toggles every reference cycle in run
    p_x2_toggle_r3: assert property (@(posedge clk_ref) disable iff (!pci_rst_n)
        (bp_rst_n && $past(bp_rst_n)) |-> (clk2x_n != $past(clk2x_n)));

    // R4: enable tracks reset release
    p_en_run_r4: assert property (@(posedge clk_ref) disable iff (!pci_rst_n)
        bp_rst_n |-> !clk2x_en_n);
    p_en_hold_r4: assert property (@(posedge clk_ref) disable iff (!pci_rst_n)
        !bp_rst_n |-> clk2x_en_n);

    // R5: reset leaves on a backplane rising edge
    p_rst_edge_r5: assert property (@(posedge clk_ref) disable iff (!pci_rst_n)
        $rose(bp_rst_n) |-> $rose(bp_clk_n));

    // R6: no interrupt drive while the backplane is in reset
    p_int_quiet_r6: assert property (@(posedge clk_ref) disable iff (!pci_rst_n)
        !bp_rst_n |-> !pci_int_oe);
endmodule

bind bpclk_gen bpg_chk u_chk (
    .clk_ref    (clk_ref),
    .pci_rst_n  (pci_rst_n),
    .bp_clk_n   (bp_clk_n),
    .clk2x_n    (clk2x_n),
    .clk2x_en_n (clk2x_en_n),
    .bp_rst_n   (bp_rst_n),
    .pci_int_oe (pci_int_oe)
);

// File: tb/sim_bpclk_gen.sv
module sim_bpclk_gen;
    localparam int RST_CYC = 4;

    logic clk_ref   = 1'b0;
    logic pci_rst_n = 1'b0;
    logic irq_en    = 1'b1;
    logic bp_irq_n  = 1'b0;
    logic bp_clk_n, clk2x_n, clk2x_en_n, bp_rst_n, pci_int_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk_ref = ~clk_ref;

    bpclk_gen #(.BP_RST_CYCLES(RST_CYC), .SYNC_STAGES(2)) u0 (
        .clk_ref    (clk_ref),
        .pci_rst_n  (pci_rst_n),
        .irq_en     (irq_en),
        .bp_irq_n   (bp_irq_n),
        .bp_clk_n   (bp_clk_n),
        .clk2x_n    (clk2x_n),
        .clk2x_en_n (clk2x_en_n),
        .bp_rst_n   (bp_rst_n),
        .pci_int_oe (pci_int_oe)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk_ref);
        @(negedge clk_ref);
    endtask

    task automatic reset_state(input string tag);
        chk({"R1 bp_rst_n ", tag}, bp_rst_n, 0);
        chk({"R1 pci_int_oe ", tag}, pci_int_oe, 0);
        chk({"R1 clk2x_en_n ", tag}, clk2x_en_n, 1);
        chk({"R1 bp_clk_n ", tag}, bp_clk_n, 0);
        chk({"R1 clk2x_n ", tag}, clk2x_n, 0);
    endtask

    // Release reset, count backplane rises until reset leaves (R5)
    task automatic release_seq();
        int rises = 0;
        int first = -1;
        logic prev;
        @(negedge clk_ref);
        pci_rst_n = 1'b1;
        prev = bp_clk_n;
        for (int g = 1; g < 200; g++) begin
            cyc(1);
            if (bp_clk_n && !prev && first < 0) first = g;
            if (bp_rst_n) begin
                chk("R5 reset leaves on clock rise", int'(bp_clk_n && !prev), 1);
                break;
            end
            chk("R4 enable withdrawn during stretch", clk2x_en_n, 1);
            chk("R6 no drive during stretch", pci_int_oe, 0);
            if (bp_clk_n && !prev) rises++;
            prev = bp_clk_n;
        end
        chk("R5 first rise after sync", first, 3);
        chk("R5 rises held in reset", rises, RST_CYC);
        chk("R5 reset released", bp_rst_n, 1);
    endtask

    // Clock shape from the release point (k = 0 just after a rise)
    task automatic shape_sweep();
        for (int k = 0; k < 48; k++) begin
            chk("R2 backplane clock shape", bp_clk_n, int'((k % 4) != 3));
            chk("R3 double-rate clock phase", clk2x_n, int'((k % 2) == 0));
            chk("R4 enable in run", clk2x_en_n, 0);
            cyc(1);
        end
    endtask

    initial begin
        cyc(6);
        reset_state("held");
        release_seq();
        shape_sweep();

        // R6: sweep enable and request
        for (int e = 0; e < 2; e++) begin
            for (int r = 0; r < 2; r++) begin
                irq_en   = e[0];
                bp_irq_n = !r[0];
                cyc(4);
                chk("R6 forward gate", pci_int_oe, e & r);
            end
        end

        // R6: enable latency of 2 edges
        irq_en = 1'b0; bp_irq_n = 1'b0; cyc(4);
        irq_en = 1'b1;
        cyc(1); chk("R6 enable latency early", pci_int_oe, 0);
        cyc(1); chk("R6 enable latency", pci_int_oe, 1);

        // R7: request latency of 3 edges, both directions
        bp_irq_n = 1'b1;
        cyc(2); chk("R7 release early", pci_int_oe, 1);
        cyc(1); chk("R7 release", pci_int_oe, 0);
        bp_irq_n = 1'b0;
        cyc(2); chk("R7 assert early", pci_int_oe, 0);
        cyc(1); chk("R7 assert", pci_int_oe, 1);

        // R1: asynchronous reset in mid-run
        @(posedge clk_ref);
        #5 pci_rst_n = 1'b0;
        #1 reset_state("async");
        cyc(3);
        reset_state("reheld");
        release_seq();
        shape_sweep();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_ref);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule